// File: doc/BRIEF.md
# Regulator Start-Up and Fault Supervisor

This block is the digital sequencer for a single-phase buck regulator controller. The analog side stays outside it. The comparators, the reference DAC and the gate drivers pass their decisions in as synchronous flags. In return the block produces:

- a reference code that ramps from zero to full scale at a fixed slew;
- a switching-enable signal;
- a force-both-gates-low signal;
- a low-side force-on signal used while an overvoltage is latched;
- a 3-bit status code that selects the pull-down strength of an open-drain good/fault pin.

A host reading that pin can tell which kind of fault stopped the converter.

A start needs both the enable input and the supply-good flag. Switching stops in the same cycle that enable falls. Undervoltage, overcurrent and overvoltage each latch the converter off, and each class has its own rule for being cleared. Over-temperature pauses switching without latching anything. When several faults appear, the status code keeps the first one.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: While `por_ok_i` is low the block sits in its power-on state on the next cycle: status code 3'b100 (undefined), `pwm_en_o` low, ramp code zero. Every fault latch is cleared, and every fault input is ignored.
- R2: A start happens one cycle after `en_i` and `por_ok_i` are both high with no fault latched. `pwm_en_o` is high from that cycle. While `en_i` is low the ramp code stays at zero.
- R3: From a start, the ramp code begins at 0 and rises by exactly one every `STEP_CYC` cycles. It stops at full scale, 2^`RAMP_W`-1.
- R4: From the start cycle the status code is 3'b001 (weak pull-down). Exactly `PG_DELAY_CYC` cycles after the start it becomes 3'b000 (released).
- R5: The status codes are fixed as follows: 3'b000 released, 3'b001 weak (soft-start, converter off or undervoltage), 3'b010 medium (overvoltage), 3'b011 strong (overcurrent or short circuit), 3'b100 undefined (supply not good).
- R6: `pwm_en_o` falls in the same cycle that `en_i` goes low. On the next cycle the status code is 3'b001 and the ramp code is zero.
- R7: `uv_i` counts only after the status has been released; during the ramp it is ignored. Once latched, an undervoltage forces `pwm_en_o` low, the ramp code to zero and the status to 3'b001. It is cleared only by `en_i` low or loss of `por_ok_i`.
- R8: `oc_i` or `sc_i` during ramp or run latches an overcurrent: status 3'b011, `pwm_en_o` low, ramp code zero. It is cleared only by `en_i` low or loss of `por_ok_i`.
- R9: `ov_hi_i` during ramp or run latches an overvoltage with status 3'b010. Taking `en_i` low neither clears it nor restarts the converter. Only loss of `por_ok_i` clears it.
- R10: While the overvoltage is latched, `lg_on_o` goes high the cycle after `ov_hi_i` and low the cycle after `ov_lo_i`. With neither flag set it holds its value.
- R11: Once a fault is latched, later faults do not change the status code until a clear.
- R12: `ot_i` during ramp or run raises `gate_low_o` and drops `pwm_en_o` on the next cycle, leaving the status code unchanged. Both return the cycle after `ot_i` falls or `en_i` goes low; nothing is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| por_ok_i | input | 1 | Bias supply above power-on threshold |
| uv_i | input | 1 | Feedback below undervoltage threshold |
| ov_hi_i | input | 1 | Feedback above rising overvoltage threshold |
| ov_lo_i | input | 1 | Feedback below falling overvoltage threshold |
| oc_i | input | 1 | Valley-current overcurrent decision |
| sc_i | input | 1 | Short-circuit decision |
| ot_i | input | 1 | Die over-temperature flag (hysteresis applied outside) |
| ramp_code_o | output | RAMP_W | Soft-start reference code |
| pwm_en_o | output | 1 | Switching enable |
| gate_low_o | output | 1 | Force both gate drivers low |
| lg_on_o | output | 1 | Force low-side gate on during overvoltage |
| pg_code_o | output | 3 | Good/fault pin pull-down selection |

## Verification
The bench attacks the clearing asymmetry: it drops enable while an overvoltage is latched. A design that shares one clear rule for all faults would show the weak code there and restart. It then injects an overcurrent after an undervoltage and an overvoltage after an overcurrent; letting the newest fault win would flip the status code. It also holds the low-side comparator flags between thresholds to catch a follower that does not hold, and it raises undervoltage during the ramp, which a supervisor that watches it too early would latch. Finally it checks the cycle counts of the ramp steps, the full-scale stop and the status release, where a design off by one register would move each edge by one cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    PG_RELEASE = 3'b000,
    PG_WEAK    = 3'b001,
    PG_MED     = 3'b010,
    PG_STRONG  = 3'b011,
    PG_UNDEF   = 3'b100
  } pg_code_e;

  typedef enum logic [2:0] {
    ST_POR, ST_OFF, ST_RAMP, ST_RUN, ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE, FC_UV, FC_OV, FC_OC
  } fault_cls_e;

  // status pin selection from sequencer state and latched class
  function automatic pg_code_e pg_encode(seq_state_e st, fault_cls_e cls);
    pg_code_e r;
    if (st == ST_POR)          r = PG_UNDEF;
    else if (cls == FC_OC)     r = PG_STRONG;
    else if (cls == FC_OV)     r = PG_MED;
    else if (cls == FC_UV)     r = PG_WEAK;
    else if (st == ST_RUN)     r = PG_RELEASE;
    else                       r = PG_WEAK;
    return r;
  endfunction

  // simultaneous new faults: overcurrent over overvoltage over undervoltage
  function automatic fault_cls_e fault_pick(logic uv, logic ov, logic oc);
    fault_cls_e r;
    if (oc)      r = FC_OC;
    else if (ov) r = FC_OV;
    else if (uv) r = FC_UV;
    else         r = FC_NONE;
    return r;
  endfunction

endpackage

// File: rtl/pss_ramp_timer.sv
module pss_ramp_timer #(
  parameter int RAMP_W       = 6,
  parameter int STEP_CYC     = 4,
  parameter int PG_DELAY_CYC = 460
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              advance_i,
  output logic [RAMP_W-1:0] ramp_q_o,
  output logic              pg_done_o
);
  localparam int STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int PG_W   = (PG_DELAY_CYC > 1) ? $clog2(PG_DELAY_CYC) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);
  localparam logic [PG_W-1:0]   PG_LAST   = PG_W'(PG_DELAY_CYC - 1);

  logic [STEP_W-1:0] step_cnt;
  logic [PG_W-1:0]   pg_cnt;
  logic              step_wrap;
  logic              ramp_full;

  assign step_wrap = (step_cnt == STEP_LAST);
  assign ramp_full = &ramp_q_o;
  assign pg_done_o = advance_i && (pg_cnt == PG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      ramp_q_o <= '0;
      pg_cnt   <= '0;
    end else if (clear_i) begin
      step_cnt <= '0;
      ramp_q_o <= '0;
      pg_cnt   <= '0;
    end else if (advance_i) begin
      step_cnt <= step_wrap ? '0 : step_cnt + 1'b1;
      if (step_wrap && !ramp_full) ramp_q_o <= ramp_q_o + 1'b1;
      if (pg_cnt != PG_LAST)       pg_cnt   <= pg_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pss_fault_latch.sv
module pss_fault_latch import pss_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok_i,
  input  logic       en_i,
  input  logic       watch_uv_i,
  input  logic       watch_any_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       oc_i,
  output fault_cls_e cls_o,
  output logic       set_o
);
  fault_cls_e cand;

  always_comb begin
    cand  = fault_pick(uv_i && watch_uv_i, ov_i && watch_any_i, oc_i && watch_any_i);
    set_o = (cls_o == FC_NONE) && (cand != FC_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          cls_o <= FC_NONE;
    else if (!por_ok_i)                                  cls_o <= FC_NONE;
    else if (!en_i && (cls_o == FC_UV || cls_o == FC_OC)) cls_o <= FC_NONE;
    else if (set_o)                                      cls_o <= cand;
  end
endmodule

// File: rtl/pss_lowside_follow.sv
module pss_lowside_follow (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic lg_state_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lg_state_o <= 1'b0;
    else if (!por_ok_i)  lg_state_o <= 1'b0;
    else if (above_hi_i) lg_state_o <= 1'b1;
    else if (below_lo_i) lg_state_o <= 1'b0;
  end
endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor import pss_pkg::*; #(
  parameter int RAMP_W       = 6,
  parameter int STEP_CYC     = 4,
  parameter int PG_DELAY_CYC = 460
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              por_ok_i,
  input  logic              uv_i,
  input  logic              ov_hi_i,
  input  logic              ov_lo_i,
  input  logic              oc_i,
  input  logic              sc_i,
  input  logic              ot_i,
  output logic [RAMP_W-1:0] ramp_code_o,
  output logic              pwm_en_o,
  output logic              gate_low_o,
  output logic              lg_on_o,
  output logic [2:0]        pg_code_o
);
  seq_state_e        st_q, st_d;
  fault_cls_e        fault_cls;
  logic              fault_set;
  logic              active;
  logic              pg_done;
  logic              ot_act;
  logic              lg_state;
  logic [RAMP_W-1:0] ramp_q;

  assign active = (st_q == ST_RAMP) || (st_q == ST_RUN);

  pss_ramp_timer #(
    .RAMP_W(RAMP_W), .STEP_CYC(STEP_CYC), .PG_DELAY_CYC(PG_DELAY_CYC)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clear_i(!active), .advance_i(active && !ot_act),
    .ramp_q_o(ramp_q), .pg_done_o(pg_done)
  );

  pss_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por_ok_i), .en_i(en_i),
    .watch_uv_i((st_q == ST_RUN) && en_i), .watch_any_i(active && en_i),
    .uv_i(uv_i), .ov_i(ov_hi_i), .oc_i(oc_i || sc_i),
    .cls_o(fault_cls), .set_o(fault_set)
  );

  pss_lowside_follow u_lg (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por_ok_i),
    .above_hi_i(ov_hi_i), .below_lo_i(ov_lo_i), .lg_state_o(lg_state)
  );

  always_comb begin
    st_d = st_q;
    if (!por_ok_i) st_d = ST_POR;
    else begin
      case (st_q)
        ST_POR:  st_d = ST_OFF;
        ST_OFF:  if (en_i && fault_cls == FC_NONE) st_d = ST_RAMP;
        ST_RAMP: if (!en_i) st_d = ST_OFF;
                 else if (fault_set) st_d = ST_HALT;
                 else if (pg_done) st_d = ST_RUN;
        ST_RUN:  if (!en_i) st_d = ST_OFF;
                 else if (fault_set) st_d = ST_HALT;
        ST_HALT: if (!en_i && fault_cls != FC_OV) st_d = ST_OFF;
        default: st_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POR;
      ot_act <= 1'b0;
    end else begin
      st_q   <= st_d;
      ot_act <= por_ok_i && en_i && active && ot_i;
    end
  end

  assign ramp_code_o = active ? ramp_q : '0;
  assign pwm_en_o    = en_i && active && !ot_act;
  assign gate_low_o  = ot_act;
  assign lg_on_o     = (fault_cls == FC_OV) && lg_state && !ot_act;
  assign pg_code_o   = pg_encode(st_q, fault_cls);
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int RAMP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              por_ok_i,
  input logic [RAMP_W-1:0] ramp_code_o,
  input logic              pwm_en_o,
  input logic              gate_low_o,
  input logic              lg_on_o,
  input logic [2:0]        pg_code_o
);
  assert_por_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok_i |=> (pg_code_o == 3'b100) && !pwm_en_o);

  assert_ramp_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code_o != $past(ramp_code_o)) && (ramp_code_o != '0)
      |-> (ramp_code_o == $past(ramp_code_o) + 1'b1));

  assert_en_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_en_o);

  assert_ov_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_code_o == 3'b010) && por_ok_i |=> (pg_code_o == 3'b010));

  assert_lg_only_ov_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lg_on_o |-> (pg_code_o == 3'b010));

  assert_first_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_code_o == 3'b011) && por_ok_i && en_i |=> (pg_code_o == 3'b011));

  assert_ot_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    gate_low_o |-> !pwm_en_o && !lg_on_o);
endmodule

bind pwr_seq_supervisor pss_checker #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .por_ok_i(por_ok_i),
  .ramp_code_o(ramp_code_o), .pwm_en_o(pwm_en_o), .gate_low_o(gate_low_o),
  .lg_on_o(lg_on_o), .pg_code_o(pg_code_o)
);

// File: tb/tb_pwr_seq_supervisor.sv
`timescale 1ns/100ps
module tb_pwr_seq_supervisor;
  localparam int RW = 6, SC = 4, PGD = 460;
  localparam int FULL = (1 << RW) - 1;
  localparam int S_RAMP = 0, S_PWM = 1, S_GL = 2, S_LG = 3, S_PG = 4;
  localparam int REL = 0, WEAK = 1, MED = 2, STR = 3, UND = 4;

  logic clk = 0, rst_n = 0, en = 0, por = 0, uv = 0, ovh = 0, ovl = 0;
  logic oc = 0, sc = 0, ot = 0;
  logic [RW-1:0] ramp;
  logic pwm, glow, lgon;
  logic [2:0] pg;

  typedef struct { int cyc; int sel; int val; string tag; } exp_t;
  exp_t q[$];
  int cyc_n = 0, n_run = 0, n_fail = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  pwr_seq_supervisor #(.RAMP_W(RW), .STEP_CYC(SC), .PG_DELAY_CYC(PGD)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .por_ok_i(por), .uv_i(uv),
    .ov_hi_i(ovh), .ov_lo_i(ovl), .oc_i(oc), .sc_i(sc), .ot_i(ot),
    .ramp_code_o(ramp), .pwm_en_o(pwm), .gate_low_o(glow), .lg_on_o(lgon),
    .pg_code_o(pg));

  function automatic int pick(int sel);
    case (sel)
      S_RAMP:  return int'(ramp);
      S_PWM:   return int'(pwm);
      S_GL:    return int'(glow);
      S_LG:    return int'(lgon);
      default: return int'(pg);
    endcase
  endfunction

  task automatic step(int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic exp_in(int d, int sel, int val, string tag);
    exp_t e;
    e.cyc = cyc_n + d; e.sel = sel; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expectations due in this cycle and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc_n) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.cyc < cyc_n || pick(e.sel) != e.val) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d cycle=%0d",
                 e.tag, e.sel, pick(e.sel), e.val, e.cyc);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(2);
    exp_in(0, S_PG, UND, "R1"); exp_in(0, S_PWM, 0, "R1");
    exp_in(0, S_RAMP, 0, "R1"); exp_in(0, S_GL, 0, "R1");
    oc = 1; ovh = 1; en = 1; step(3);
    exp_in(0, S_PG, UND, "R1 faults ignored"); exp_in(0, S_PWM, 0, "R1");
    oc = 0; ovh = 0; en = 0;
    por = 1; step(1);
    exp_in(0, S_PG, WEAK, "R2/R5 off");
    step(10);
    exp_in(0, S_RAMP, 0, "R2 en low"); exp_in(0, S_PWM, 0, "R2");
    // start and ramp timing
    en = 1; step(1);
    exp_in(0, S_PWM, 1, "R2"); exp_in(0, S_RAMP, 0, "R3"); exp_in(0, S_PG, WEAK, "R4");
    exp_in(SC - 1, S_RAMP, 0, "R3"); exp_in(SC, S_RAMP, 1, "R3");
    exp_in(10 * SC, S_RAMP, 10, "R3"); exp_in(FULL * SC, S_RAMP, FULL, "R3");
    exp_in(FULL * SC + 30, S_RAMP, FULL, "R3 saturate");
    exp_in(PGD - 1, S_PG, WEAK, "R4"); exp_in(PGD, S_PG, REL, "R4/R5");
    step(PGD + 2);
    // enable drop
    en = 0; exp_in(0, S_PWM, 0, "R6 same cycle");
    step(1);
    exp_in(0, S_PG, WEAK, "R6"); exp_in(0, S_RAMP, 0, "R6");
    // undervoltage
    en = 1; step(1);
    uv = 1; step(5);
    exp_in(0, S_PG, WEAK, "R7 uv ignored in ramp"); exp_in(0, S_PWM, 1, "R7");
    uv = 0; step(PGD);
    exp_in(0, S_PG, REL, "R4");
    uv = 1; step(1);
    exp_in(0, S_PG, WEAK, "R7"); exp_in(0, S_PWM, 0, "R7"); exp_in(0, S_RAMP, 0, "R7");
    uv = 0; step(4);
    exp_in(0, S_PWM, 0, "R7 latched"); exp_in(0, S_PG, WEAK, "R7");
    oc = 1; step(2);
    exp_in(0, S_PG, WEAK, "R11 uv kept");
    oc = 0;
    en = 0; step(1); en = 1; step(1);
    exp_in(0, S_PWM, 1, "R7 cleared by en");
    // overcurrent in ramp
    step(5); oc = 1; step(1);
    exp_in(0, S_PG, STR, "R8/R5"); exp_in(0, S_PWM, 0, "R8"); exp_in(0, S_RAMP, 0, "R8");
    oc = 0; ovh = 1; step(1);
    exp_in(0, S_PG, STR, "R11 oc kept"); exp_in(0, S_LG, 0, "R11");
    ovh = 0; step(3);
    exp_in(0, S_PG, STR, "R8 holds");
    en = 0; step(1);
    exp_in(0, S_PG, WEAK, "R8 cleared");
    en = 1; step(1);
    exp_in(0, S_PWM, 1, "R8 restart");
    sc = 1; step(1);
    exp_in(0, S_PG, STR, "R8 short");
    sc = 0; en = 0; step(1); en = 1; step(1);
    // overvoltage
    ovh = 1; step(1);
    exp_in(0, S_PG, MED, "R9/R5"); exp_in(0, S_PWM, 0, "R9"); exp_in(0, S_LG, 1, "R10");
    ovh = 0; step(2);
    exp_in(0, S_LG, 1, "R10 hold");
    ovl = 1; step(1);
    exp_in(0, S_LG, 0, "R10 off");
    ovl = 0; step(2);
    exp_in(0, S_LG, 0, "R10 hold low");
    ovh = 1; step(1);
    exp_in(0, S_LG, 1, "R10 on again");
    ovh = 0;
    en = 0; step(3);
    exp_in(0, S_PG, MED, "R9 en low no clear"); exp_in(0, S_LG, 1, "R10");
    en = 1; step(3);
    exp_in(0, S_PWM, 0, "R9 no restart"); exp_in(0, S_PG, MED, "R9"); exp_in(0, S_RAMP, 0, "R9");
    por = 0; step(1);
    exp_in(0, S_PG, UND, "R9 por clear"); exp_in(0, S_LG, 0, "R1");
    por = 1; step(1);
    exp_in(0, S_PG, WEAK, "R1 exit");
    step(1);
    exp_in(0, S_PWM, 1, "R2 restart");
    // over-temperature
    step(PGD + 1);
    exp_in(0, S_PG, REL, "R4");
    ot = 1; step(1);
    exp_in(0, S_GL, 1, "R12"); exp_in(0, S_PWM, 0, "R12"); exp_in(0, S_PG, REL, "R12");
    step(3);
    exp_in(0, S_PG, REL, "R12 no latch");
    ot = 0; step(1);
    exp_in(0, S_GL, 0, "R12 resume"); exp_in(0, S_PWM, 1, "R12");
    ot = 1; step(1); en = 0; step(1);
    exp_in(0, S_GL, 0, "R12 en clears");
    ot = 0;
    step(3);
    while (q.size() > 0) step(1);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule